// File: doc/BRIEF.md
# Cycle Countdown Timer with Swap Load

This block is a down-counter that counts clock cycles and signals the interrupt control unit when a programmed interval has run out. A core loads it when it executes its timer instruction. The core supplies the new count, taken from a source register, together with that register's index. The block answers with the count it held just before the load, which the core writes to the destination register. A single write therefore sets a new interval and reads back what was left of the old one.

A count of zero means the timer is stopped. A nonzero count drops by one on every clock. When the count steps from one down to zero, the block sends a single-cycle interrupt pulse. The block does not mask that pulse and does not hold it pending. When the source register index is zero, the load value is treated as zero whatever data comes with it. A load from register zero therefore stops the timer and returns the remaining count.

The load side uses a valid/ready handshake. The block never applies back-pressure, so ready is always high and a write takes effect on every clock edge where valid is high. The result side has a valid flag and no ready. It presents each old count for exactly one cycle, and the receiver must take it in that cycle.

Top module: `ctm_countdown`

## Requirements
- R1: After reset the count is zero, `irq_o` and `rd_valid_o` are low, and a later swap returns 0.
- R2: While the count is nonzero and no write is accepted, the count decreases by exactly one on each clock edge.
- R3: `irq_o` is high in the cycle after the edge on which a decrement takes the count from 1 to 0, and at no other time. A load of N made on edge e0 gives the pulse after edge e0+N.
- R4: A count of zero stays zero without a write and never raises `irq_o`.
- R5: On the edge after an accepted write, `rd_valid_o` is high for one cycle and `rd_old_o` holds the count from before that write. Without a write, `rd_valid_o` is low.
- R6: A write with `ld_src_i` equal to 0 loads zero, whatever `ld_value_i` holds.
- R7: A write on the same edge as a pending decrement takes priority. The loaded value replaces the count, the returned value is the count before that edge, and a write while the count is 1 raises no interrupt.
- R8: `ld_ready_o` is high at all times, including during reset.
- R9: `irq_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ld_valid_i | input | 1 | Load request (timer instruction executes) |
| ld_ready_o | output | 1 | Always high; block never stalls a load |
| ld_value_i | input | CNT_W | New count from the source register |
| ld_src_i | input | IDX_W | Source register index; 0 forces a zero load |
| rd_valid_o | output | 1 | Old count valid, one cycle after the load |
| rd_old_o | output | CNT_W | Count held before the accepted load |
| irq_o | output | 1 | One-cycle pulse on 1-to-0 expiry |

## Verification
The assertions assume that `ld_valid_i`, `ld_value_i` and `ld_src_i` are stable around each rising edge. They also assume that a write counts as accepted whenever valid is high, because ready never drops. The bench changes every input only on the falling edge and holds each write for exactly one rising edge. It leaves idle gaps of known length between writes, so the count seen at each swap follows directly from the previous load and the gap.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int unsigned CTM_CNT_W = 32;
  localparam int unsigned CTM_IDX_W = 5;

  typedef enum logic [1:0] {
    CTM_HOLD = 2'd0,
    CTM_DEC  = 2'd1,
    CTM_LOAD = 2'd2
  } ctm_op_e;
endpackage

// File: rtl/ctm_load_gate.sv
module ctm_load_gate #(
  parameter int unsigned CNT_W = ctm_pkg::CTM_CNT_W,
  parameter int unsigned IDX_W = ctm_pkg::CTM_IDX_W
) (
  input  logic [CNT_W-1:0] value_i,
  input  logic [IDX_W-1:0] src_i,
  output logic [CNT_W-1:0] value_o
);
  localparam logic [IDX_W-1:0] ZERO_REG = '0;

  always_comb begin
    value_o = value_i;
    if (src_i == ZERO_REG) value_o = '0;
  end
endmodule

// File: rtl/ctm_down_counter.sv
module ctm_down_counter #(
  parameter int unsigned CNT_W = ctm_pkg::CTM_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  import ctm_pkg::*;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire_q;
  ctm_op_e          op;

  always_comb begin
    if (load_i)              op = CTM_LOAD;
    else if (cnt_q != '0)    op = CTM_DEC;
    else                     op = CTM_HOLD;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= (op == CTM_DEC) && (cnt_q == ONE);
      case (op)
        CTM_LOAD: cnt_q <= load_val_i;
        CTM_DEC:  cnt_q <= cnt_q - ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = expire_q;

  // R2
  p_dec_by_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  // R4
  p_zero_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0 && !expire_q));
  // R7
  p_load_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i) && !expire_q));
endmodule

// File: rtl/ctm_swap_result.sv
module ctm_swap_result #(
  parameter int unsigned CNT_W = ctm_pkg::CTM_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] old_o
);
  logic             valid_q;
  logic [CNT_W-1:0] old_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      old_q   <= '0;
    end else begin
      valid_q <= take_i;
      if (take_i) old_q <= cnt_i;
    end
  end

  assign valid_o = valid_q;
  assign old_o   = old_q;

  // R5
  p_swap_old_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (valid_q && old_q == $past(cnt_i)));
  p_no_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> !valid_q);
endmodule

// File: rtl/ctm_countdown.sv
module ctm_countdown #(
  parameter int unsigned CNT_W = ctm_pkg::CTM_CNT_W,
  parameter int unsigned IDX_W = ctm_pkg::CTM_IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_valid_i,
  output logic             ld_ready_o,
  input  logic [CNT_W-1:0] ld_value_i,
  input  logic [IDX_W-1:0] ld_src_i,
  output logic             rd_valid_o,
  output logic [CNT_W-1:0] rd_old_o,
  output logic             irq_o
);
  logic             accept;
  logic [CNT_W-1:0] gated_val;
  logic [CNT_W-1:0] cnt;

  assign ld_ready_o = 1'b1;
  assign accept     = ld_valid_i && ld_ready_o;

  ctm_load_gate #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_gate (
    .value_i (ld_value_i),
    .src_i   (ld_src_i),
    .value_o (gated_val)
  );

  ctm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (gated_val),
    .cnt_o      (cnt),
    .expire_o   (irq_o)
  );

  ctm_swap_result #(.CNT_W(CNT_W)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (accept),
    .cnt_i   (cnt),
    .valid_o (rd_valid_o),
    .old_o   (rd_old_o)
  );

  // R3
  p_irq_on_expiry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && cnt == CNT_W'(1)) |=> irq_o);
  // R6
  p_x0_loads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && ld_src_i == '0) |=> (cnt == '0));
  // R9
  p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: tb/sim_ctm_countdown.sv
module sim_ctm_countdown;
  localparam int W = 32;
  localparam int N_VEC = 9;

  localparam logic [31:0] TV_VAL [N_VEC] = '{32'd100, 32'd50, 32'd7, 32'd999, 32'd20,
                                             32'd0, 32'hFFFF_FFFF, 32'd3, 32'd77};
  localparam logic [4:0]  TV_SRC [N_VEC] = '{5'd3, 5'd7, 5'd1, 5'd0, 5'd2, 5'd4, 5'd31, 5'd5, 5'd0};
  localparam int          TV_GAP [N_VEC] = '{0, 10, 3, 2, 5, 0, 4, 1, 0};
  localparam logic [31:0] TV_OLD [N_VEC] = '{32'd0, 32'd90, 32'd47, 32'd5, 32'd0,
                                             32'd20, 32'd0, 32'hFFFF_FFFE, 32'd3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [W-1:0] ld_value = '0;
  logic [4:0] ld_src = '0;
  logic rd_valid;
  logic [W-1:0] rd_old;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;
  int irq_seen = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ctm_countdown u0 (
    .clk_i(clk), .rst_ni(rst_n), .ld_valid_i(ld_valid), .ld_ready_o(ld_ready),
    .ld_value_i(ld_value), .ld_src_i(ld_src), .rd_valid_o(rd_valid),
    .rd_old_o(rd_old), .irq_o(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // At a negedge: drive one write across the next rising edge, return at the following negedge.
  task automatic wr(input logic [W-1:0] v, input logic [4:0] s);
    ld_valid = 1'b1; ld_value = v; ld_src = s;
    @(negedge clk);
    ld_valid = 1'b0; ld_value = '0; ld_src = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R8 ready in reset", {31'd0, ld_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    chk("R8 ready", {31'd0, ld_ready}, 32'd1);
    idle(4);
    wr(32'd0, 5'd0);
    chk("R1 count zero after reset", rd_old, 32'd0);
    chk("R5 rd_valid after write", {31'd0, rd_valid}, 32'd1);
    @(negedge clk);
    chk("R5 rd_valid low when idle", {31'd0, rd_valid}, 32'd0);

    // table walk: swap reads after known gaps (R2, R5, R6, R7)
    base = irq_seen;
    for (int i = 0; i < N_VEC; i++) begin
      idle(TV_GAP[i]);
      wr(TV_VAL[i], TV_SRC[i]);
      chk($sformatf("R2/R5/R6 vector %0d old count", i), rd_old, TV_OLD[i]);
    end
    chk("R4 no irq during table", irq_seen - base, 32'd0);

    // R3: load 5, pulse exactly after fifth decrement edge; R9 single cycle
    wr(32'd5, 5'd9);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk($sformatf("R3 irq at cycle %0d", k), {31'd0, irq}, (k == 5) ? 32'd1 : 32'd0);
    end
    // R4: stays zero, no interrupt
    base = irq_seen;
    idle(10);
    chk("R4 no irq at zero", irq_seen - base, 32'd0);
    wr(32'd0, 5'd0);
    chk("R4 count stays zero", rd_old, 32'd0);

    // R3 load 1: pulse right after next edge
    wr(32'd1, 5'd1);
    @(negedge clk);
    chk("R3 load-1 irq", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R9 irq single cycle", {31'd0, irq}, 32'd0);

    // R7: write while count is 1
    base = irq_seen;
    wr(32'd2, 5'd2);
    idle(1);
    wr(32'd9, 5'd3);
    chk("R7 old value before edge", rd_old, 32'd1);
    chk("R7 no irq on overridden expiry", {31'd0, irq}, 32'd0);
    wr(32'd0, 5'd0);
    chk("R7 loaded value wins", rd_old, 32'd9);
    idle(3);
    chk("R7 no irq after override", irq_seen - base, 32'd0);

    // R6: nonzero data from x0 stops timer
    wr(32'd40, 5'd6);
    wr(32'd500, 5'd0);
    chk("R6 swap returns remaining", rd_old, 32'd40);
    idle(50);
    wr(32'd0, 5'd0);
    chk("R6 x0 loaded zero", rd_old, 32'd0);
    chk("R6 no irq after stop", irq_seen - base, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule